// File: doc/BRIEF.md
# Four-Mode Serial Port with Address Filtering

A full-duplex serial port with one control register and one data register on a small register bus. Two mode bits pick one of four framings. The first is a synchronous 8-bit shifter, where the port drives a clock on the transmit pin and moves data on the receive pin. The second is a 10-bit asynchronous frame. The last two are 11-bit asynchronous frames that carry a ninth data bit, which software sets per frame. The two 11-bit modes differ only in where their bit rate comes from.

A byte written to the data address is sent at once. A read of the same address returns a separate receive holding register. The receiver shifts into its own register and copies to the holding register only when a frame completes, so the next frame can arrive while software reads the last one. When a filter bit is set, receive-done is held back for frames whose ninth bit is 0 in the 11-bit modes, and for frames with a bad stop bit in the 10-bit mode. This lets a node on a shared line ignore traffic that is not addressed to it. Two flags signal transmit-done and receive-done. Only software clears them.

The variable bit rate comes from an external timer's one-cycle overflow pulse. The fixed rates come from the clock.

Top module: `sio_port`

## Requirements
- R1: After reset the control register reads 0x00, `txd` is 1, `rxd_oe` is 0 and both flag outputs are 0. The control byte is laid out as bits [7:6] mode, [5] filter, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit-done, [0] receive-done. `bus_addr` 0 selects control and 1 selects data.
- R2: In mode 0, a data write shifts 8 bits LSB first on `rxd_out` with `rxd_oe` high. Each bit lasts SHIFT_DIV (12) clocks. `txd` is low for the first half of each bit and high for the second. Transmit-done rises 8×SHIFT_DIV clocks after the write.
- R3: In mode 0 with receive enable at 1 and receive-done at 0, the port drives the same clock on `txd` and samples `rxd_in` near each rising edge, LSB first. After 8 bits it sets receive-done and loads the byte. The received ninth bit is left unchanged.
- R4: Mode 1 sends a start bit of 0, 8 data bits LSB first and a stop bit of 1. Each bit lasts 16 sample ticks. In modes 1 and 3 a tick is every overflow pulse when `rate_dbl` is 1, and every second pulse when it is 0. `txd` idles at 1.
- R5: Modes 2 and 3 send 11 bits: start, 8 data bits, the transmit ninth bit, then stop. In mode 2 one bit lasts 64 clocks, or 32 clocks when `rate_dbl` is 1.
- R6: Transmit-done sets when the stop bit begins. Both flags fall only on a control write.
- R7: A mode 1 frame that is received loads its byte, copies the stop bit into the received ninth bit and sets receive-done.
- R8: A mode 3 frame that is received copies its ninth bit into the received ninth bit.
- R9: In modes 2 and 3 with the filter set, a frame whose ninth bit is 0 leaves receive-done, the holding register and the received ninth bit unchanged. A frame whose ninth bit is 1 is accepted.
- R10: In mode 1 with the filter set, a frame whose stop bit samples 0 is not accepted.
- R11: A frame that completes while receive-done is still 1 is discarded.
- R12: A low pulse shorter than half a bit, which reads 1 at the start bit's mid-point, is abandoned. The receiver then takes the next valid frame.
- R13: With receive enable at 0, no frame is received.
- R14: A data write does not change what a data read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 1 | 0 selects control, 1 selects data |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| rate_dbl | input | 1 | Rate-doubling bit |
| rxd_in | input | 1 | Receive pin input |
| rxd_out | output | 1 | Receive pin output value (mode 0 transmit) |
| rxd_oe | output | 1 | Receive pin output enable |
| txd | output | 1 | Transmit line, or shift clock in mode 0 |
| tx_irq | output | 1 | Transmit-done flag |
| rx_irq | output | 1 | Receive-done flag |

## Verification
A receiver phase counter that drifts moves the mid-bit samples. The result is a wrong byte in the holding register, or a lost receive-done, which becomes visible at the end of that frame's stop-bit sample. A wrong bit index in the transmitter shows up on `txd` within one bit time: a data bit slips, or transmit-done fires a bit early or late. A faulty filter or overrun guard leaves the holding register or the received ninth bit in a state that the next control and data read exposes directly.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    SM_SHIFT  = 2'd0,
    SM_UART8  = 2'd1,
    SM_UART9F = 2'd2,
    SM_UART9V = 2'd3
  } sio_mode_e;

  // last terminal count of the sample-tick prescaler
  function automatic int rate_term(sio_mode_e m, logic dbl);
    if (m == SM_UART9F) return dbl ? 1 : 3;
    return dbl ? 0 : 1;
  endfunction

  // index of the stop bit in an asynchronous frame
  function automatic int stop_idx(sio_mode_e m);
    return (m == SM_UART8) ? 9 : 10;
  endfunction

  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sio_rate.sv
module sio_rate
  import sio_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  sio_mode_e mode,
  input  logic      dbl,
  input  logic      ovf,
  output logic      tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] term;
  logic          ev;

  always_comb begin
    ev   = (mode == SM_UART9F) ? 1'b1 : ovf;
    term = CW'(rate_term(mode, dbl));
    tick = (mode != SM_SHIFT) && ev && (cnt >= term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (mode == SM_SHIFT) cnt <= '0;
    else if (ev)              cnt <= (cnt >= term) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DIV0 = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  sio_mode_e mode,
  input  logic      tick,
  input  logic      load,
  input  logic [7:0] din,
  input  logic      bit9,
  output logic      line,
  output logic      d0,
  output logic      d0_oe,
  output logic      sclk_low,
  output logic      busy,
  output logic      ti_set
);
  localparam int SW = $clog2((OVS > DIV0) ? OVS : DIV0);

  logic [10:0]   sh;
  logic [3:0]    idx;
  logic [SW-1:0] sub;
  logic          m0;
  logic [3:0]    last;

  always_comb begin
    last     = 4'(stop_idx(mode));
    line     = (busy && !m0) ? sh[0] : 1'b1;
    d0       = sh[0];
    d0_oe    = busy && m0;
    sclk_low = busy && m0 && (sub < SW'(DIV0/2));
    ti_set   = (busy && m0 && sub == SW'(DIV0-1) && idx == 4'd7) ||
               (busy && !m0 && tick && sub == SW'(OVS-1) && (idx + 4'd1 == last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1; idx <= '0; sub <= '0; busy <= 1'b0; m0 <= 1'b0;
    end else if (load) begin
      case (mode)
        SM_SHIFT: sh <= {3'b111, din};
        SM_UART8: sh <= {2'b11, din, 1'b0};
        default:  sh <= {1'b1, bit9, din, 1'b0};
      endcase
      busy <= 1'b1; m0 <= (mode == SM_SHIFT); idx <= '0; sub <= '0;
    end else if (busy && m0) begin
      if (sub == SW'(DIV0-1)) begin
        sub <= '0;
        if (idx == 4'd7) busy <= 1'b0;
        else begin idx <= idx + 4'd1; sh <= {1'b1, sh[10:1]}; end
      end else sub <= sub + 1'b1;
    end else if (busy && tick) begin
      if (sub == SW'(OVS-1)) begin
        sub <= '0;
        if (idx == last) busy <= 1'b0;
        else begin idx <= idx + 4'd1; sh <= {1'b1, sh[10:1]}; end
      end else sub <= sub + 1'b1;
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DIV0 = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  sio_mode_e mode,
  input  logic      tick,
  input  logic      ren,
  input  logic      ri,
  input  logic      filt,
  input  logic      tx_busy,
  input  logic      rxs,
  output logic      sclk_low,
  output logic      start,
  output logic      accept,
  output logic [7:0] data,
  output logic      bit9
);
  localparam int SW  = $clog2((OVS > DIV0) ? OVS : DIV0);
  localparam int MID = OVS / 2;

  logic          busy, m0, s_a, s_b, bitv, m0_done, a_done;
  logic [SW-1:0] sub;
  logic [3:0]    idx, last;
  logic [8:0]    sh;

  always_comb begin
    last     = 4'(stop_idx(mode));
    bitv     = maj3(s_a, s_b, rxs);
    start    = !busy && ren &&
               ((mode == SM_SHIFT) ? (!ri && !tx_busy) : (tick && !rxs));
    m0_done  = busy && m0 && sub == SW'(DIV0-1) && idx == 4'd7;
    a_done   = busy && !m0 && tick && sub == SW'(MID+1) && idx == last;
    bit9     = (mode == SM_UART8) ? bitv : sh[8];
    data     = (mode == SM_SHIFT || mode == SM_UART8) ? sh[8:1] : sh[7:0];
    accept   = !ri && (m0_done || (a_done && (!filt || bit9)));
    sclk_low = busy && m0 && (sub < SW'(DIV0/2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; m0 <= 1'b0; sub <= '0; idx <= '0;
      sh <= '0; s_a <= 1'b1; s_b <= 1'b1;
    end else if (start) begin
      busy <= 1'b1; m0 <= (mode == SM_SHIFT); sub <= '0; idx <= '0;
    end else if (busy && m0) begin
      if (sub == SW'(DIV0/2)) sh <= {rxs, sh[8:1]};
      if (sub == SW'(DIV0-1)) begin
        sub <= '0;
        if (idx == 4'd7) busy <= 1'b0;
        else idx <= idx + 4'd1;
      end else sub <= sub + 1'b1;
    end else if (busy && tick) begin
      if (sub == SW'(MID-1)) s_a <= rxs;
      if (sub == SW'(MID))   s_b <= rxs;
      if (sub == SW'(MID+1)) begin
        if (idx == 4'd0 && bitv) busy <= 1'b0;
        else if (idx == last)    busy <= 1'b0;
        else if (idx != 4'd0)    sh <= {bitv, sh[8:1]};
      end
      if (sub == SW'(OVS-1)) begin sub <= '0; idx <= idx + 4'd1; end
      else sub <= sub + 1'b1;
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int SHIFT_DIV = 12,
  parameter int OVS = 16,
  parameter int RATE_CW = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tmr_ovf,
  input  logic       rate_dbl,
  input  logic       rxd_in,
  output logic       rxd_out,
  output logic       rxd_oe,
  output logic       txd,
  output logic       tx_irq,
  output logic       rx_irq
);
  localparam logic ADDR_CTRL = 1'b0;

  sio_mode_e  mode;
  logic       filt, ren, tb8, rb8, ti, ri;
  logic [7:0] rxbuf;
  logic       wr_ctrl, wr_data, tick, rx_meta, rxs;
  logic       tx_line, tx_d0, tx_sclk_low, tx_busy, ti_set;
  logic       rx_sclk_low, rx_start, rx_accept, rx_bit9;
  logic [7:0] rx_data;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_data = bus_wr && (bus_addr != ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rx_meta <= 1'b1; rxs <= 1'b1; end
    else begin rx_meta <= rxd_in; rxs <= rx_meta; end
  end

  sio_rate #(.CW(RATE_CW)) u_rate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dbl(rate_dbl), .ovf(tmr_ovf), .tick(tick));

  sio_tx #(.OVS(OVS), .DIV0(SHIFT_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .load(wr_data),
    .din(bus_wdata), .bit9(tb8), .line(tx_line), .d0(tx_d0), .d0_oe(rxd_oe),
    .sclk_low(tx_sclk_low), .busy(tx_busy), .ti_set(ti_set));

  sio_rx #(.OVS(OVS), .DIV0(SHIFT_DIV)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .ren(ren), .ri(ri),
    .filt(filt), .tx_busy(tx_busy), .rxs(rxs), .sclk_low(rx_sclk_low),
    .start(rx_start), .accept(rx_accept), .data(rx_data), .bit9(rx_bit9));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= SM_SHIFT; filt <= 1'b0; ren <= 1'b0; tb8 <= 1'b0;
      rb8 <= 1'b0; ti <= 1'b0; ri <= 1'b0; rxbuf <= '0;
    end else begin
      if (wr_ctrl) begin
        mode <= sio_mode_e'(bus_wdata[7:6]);
        {filt, ren, tb8, rb8, ti, ri} <= bus_wdata[5:0];
      end
      if (ti_set) ti <= 1'b1;
      if (rx_accept) begin
        ri    <= 1'b1;
        rxbuf <= rx_data;
        if (mode != SM_SHIFT) rb8 <= rx_bit9;
      end
    end
  end

  always_comb begin
    bus_rdata = (bus_addr == ADDR_CTRL) ? {mode, filt, ren, tb8, rb8, ti, ri} : rxbuf;
    txd       = (mode == SM_SHIFT) ? !(tx_sclk_low || rx_sclk_low) : tx_line;
    rxd_out   = tx_d0;
    tx_irq    = ti;
    rx_irq    = ri;
  end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk
  import sio_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctrl,
  input sio_mode_e  mode,
  input logic       rxd_oe,
  input logic       txd,
  input logic       tx_busy,
  input logic       ti,
  input logic       ri,
  input logic       ren,
  input logic       rx_accept,
  input logic       rx_start,
  input logic [7:0] rxbuf
);
  // R2
  oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> mode == SM_SHIFT);
  // R4
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && mode != SM_SHIFT) |-> txd);
  // R6
  ti_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ti) |-> $past(wr_ctrl));
  // R6
  ri_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ri) |-> $past(wr_ctrl));
  // R11
  ri_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> !ri);
  // R9
  rxbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_accept |=> $stable(rxbuf));
  // R13
  ren_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |-> ren);
endmodule

bind sio_port sio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .mode(mode), .rxd_oe(rxd_oe),
  .txd(txd), .tx_busy(tx_busy), .ti(ti), .ri(ri), .ren(ren),
  .rx_accept(rx_accept), .rx_start(rx_start), .rxbuf(rxbuf));

// File: tb/sio_port_tb.sv
module sio_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tmr_ovf = 1'b0;
  logic       rate_dbl = 1'b0;
  logic       rxd_in = 1'b1;
  logic       rxd_out, rxd_oe, txd, tx_irq, rx_irq;
  int         n_chk = 0;
  int         n_fail = 0;
  int         ovf_cnt = 0;

  always #2 clk = ~clk;

  sio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
    .rate_dbl(rate_dbl), .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
    .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq));

  // overflow pulse every third clock
  always @(negedge clk) begin
    ovf_cnt = (ovf_cnt == 2) ? 0 : ovf_cnt + 1;
    tmr_ovf = (ovf_cnt == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic send(input logic [10:0] fr, input int nb, input int b, input int lastlen);
    for (int i = 0; i < nb; i++) begin
      rxd_in = fr[i];
      wclk((i == nb - 1) ? lastlen : b);
    end
    rxd_in = 1'b1;
    wclk(2 * b);
  endtask

  // samples txd at every mid-bit after a data write; ti checked around the stop bit
  task automatic tx_frame(input string tag, input logic [10:0] fr, input int nb, input int b);
    int prev = 0;
    for (int i = 0; i < nb; i++) begin
      int tgt = b * i + b / 2;
      wclk(tgt - prev); prev = tgt;
      chk(tag, txd, fr[i]);
      if (i == nb - 2) chk({tag, " R6 ti before stop"}, tx_irq, 0);
      if (i == nb - 1) chk({tag, " R6 ti at stop"}, tx_irq, 1);
    end
    wclk(b);
  endtask

  task automatic expect_regs(input string tag, input int c, input int d);
    logic [7:0] v;
    brd(1'b0, v); chk({tag, " ctrl"}, v, c);
    brd(1'b1, v); chk({tag, " data"}, v, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    wclk(5);
    // R1 reset state
    brd(1'b0, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 txd", txd, 1); chk("R1 oe", rxd_oe, 0);
    chk("R1 irqs", {tx_irq, rx_irq}, 0);
    rst_n = 1'b1;
    wclk(3);

    // R2 mode 0 transmit
    begin
      int prev = 0;
      bwr(1'b1, 8'hA5);
      for (int i = 0; i < 8; i++) begin
        wclk(12 * i + 2 - prev); prev = 12 * i + 2;
        chk("R2 sclk low", txd, 0); chk("R2 oe", rxd_oe, 1);
        chk("R2 data", rxd_out, (8'hA5 >> i) & 1);
        wclk(6); prev += 6;
        chk("R2 sclk high", txd, 1);
      end
      wclk(95 - prev);
      chk("R2 ti not yet", tx_irq, 0);
      wclk(1);
      chk("R2 ti set", tx_irq, 1); chk("R2 oe off", rxd_oe, 0);
    end

    // R3 mode 0 receive of 0x3C
    bwr(1'b0, 8'h10);
    for (int i = 0; i < 8; i++) begin
      while (txd !== 1'b0) @(negedge clk);
      rxd_in = (8'h3C >> i) & 1;
      while (txd !== 1'b1) @(negedge clk);
    end
    wclk(20);
    rxd_in = 1'b1;
    expect_regs("R3", 8'h11, 8'h3C);
    bwr(1'b0, 8'h00);

    // R4 mode 1 transmit, bit = 48 clocks
    rate_dbl = 1'b1;
    bwr(1'b0, 8'h40);
    bwr(1'b1, 8'h5A);
    tx_frame("R4 mode1 bit", {1'b1, 1'b1, 8'h5A, 1'b0}, 10, 48);
    brd(1'b0, v); chk("R6 ti held", v, 8'h42);
    bwr(1'b0, 8'h40);
    brd(1'b0, v); chk("R6 ti cleared by write", v, 8'h40);

    // R5 mode 2 transmit, 64 then 32 clocks per bit
    rate_dbl = 1'b0;
    bwr(1'b0, 8'h88);
    bwr(1'b1, 8'hC6);
    tx_frame("R5 mode2 slow", {1'b1, 1'b1, 8'hC6, 1'b0}, 11, 64);
    rate_dbl = 1'b1;
    bwr(1'b0, 8'h80);
    bwr(1'b1, 8'h39);
    tx_frame("R5 mode2 fast", {1'b1, 1'b0, 8'h39, 1'b0}, 11, 32);

    // R7 mode 1 receive
    bwr(1'b0, 8'h50);
    send({1'b1, 1'b1, 8'hC3, 1'b0}, 10, 48, 48);
    expect_regs("R7", 8'h55, 8'hC3);
    // R14 transmit write does not alter receive read
    bwr(1'b1, 8'h11);
    brd(1'b1, v); chk("R14 data read", v, 8'hC3);
    wclk(540);
    // R11 overrun discards
    send({1'b1, 1'b1, 8'h77, 1'b0}, 10, 48, 48);
    expect_regs("R11", 8'h57, 8'hC3);

    // R10 mode 1 with filter, bad stop bit
    bwr(1'b0, 8'h70);
    send({1'b1, 1'b0, 8'h99, 1'b0}, 10, 48, 36);
    expect_regs("R10", 8'h70, 8'hC3);

    // R8 mode 3 receive, ninth bit 0
    bwr(1'b0, 8'hD0);
    send({1'b1, 1'b0, 8'h42, 1'b0}, 11, 48, 48);
    expect_regs("R8", 8'hD1, 8'h42);

    // R9 filter in mode 3
    bwr(1'b0, 8'hF0);
    send({1'b1, 1'b0, 8'h24, 1'b0}, 11, 48, 48);
    expect_regs("R9 data frame", 8'hF0, 8'h42);
    send({1'b1, 1'b1, 8'h81, 1'b0}, 11, 48, 48);
    expect_regs("R9 address frame", 8'hF5, 8'h81);

    // R12 short glitch then valid frame
    bwr(1'b0, 8'h50);
    rxd_in = 1'b0; wclk(4); rxd_in = 1'b1;
    wclk(600);
    expect_regs("R12 glitch", 8'h50, 8'h81);
    send({1'b1, 1'b1, 8'h3E, 1'b0}, 10, 48, 48);
    expect_regs("R12 recovered", 8'h55, 8'h3E);

    // R13 receive disabled
    bwr(1'b0, 8'h40);
    send({1'b1, 1'b1, 8'h55, 1'b0}, 10, 48, 48);
    expect_regs("R13", 8'h40, 8'h3E);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule